// File: doc/BRIEF.md
# UART Receive FIFO and Line Status

This block is the receive half of a byte-oriented serial port's register interface. An external deserializer presents each received byte on `rx_data` with a one-cycle `rx_valid` strobe. The block stores the bytes in a 16-entry first-in first-out buffer. Software drains the buffer through a small register bus.

The block keeps two line-status flags. Data ready shows that unread bytes are present. Overrun error shows that a byte arrived while the buffer was full. The flags are cleared by reads of different registers. A programmable trigger level in the FIFO control register drives a receive interrupt output, which the interrupt priority logic outside the block consumes.

The register map is decoded on `bus_addr`:
- Address 0 is the receive data register.
- Address 1 is the line status register: bit 0 is data ready, bit 1 is overrun.
- Address 2 is the FIFO control register, with the trigger selector in bits [7:6].
- Address 3 reads as zero.

`bus_rdata` is combinational from `bus_addr` and the current state. Side effects of a read (popping a byte, clearing the overrun flag) take place at the clock edge of the cycle in which `bus_rd` is high.

Top module: `uart_rx_fifo_stat`

## Requirements
- R1: After reset the buffer is empty, both status flags are 0, the trigger selector is 00, `rx_irq` is 0, and every register reads 0.
- R2: Bytes read from address 0 come out in arrival order, and up to 16 unread bytes are held.
- R3: The trigger selector in FIFO control bits [7:6] picks the level: 00 is 1 byte, 01 is 4 bytes, 10 is 8 bytes and 11 is 14 bytes. `rx_irq` is high whenever the stored count is at or above that level.
- R4: `rx_irq` drops in the cycle after a read of address 0 brings the count below the selected level.
- R5: A byte that arrives while 16 bytes are held, with no read of address 0 in the same cycle, replaces the newest stored byte. It also sets the overrun flag (line status bit 1), and the count stays at 16.
- R6: A read of address 1 clears the overrun flag at the following edge. If a new overrun occurs in that same cycle, the flag stays set.
- R7: Data ready (line status bit 0) is 1 exactly when unread bytes are held. A read of address 1 never clears it.
- R8: In the FIFO control register, bits [15:8] and [5:0] read as zero and ignore writes. Writes to addresses other than 2 change no register.
- R9: A read of address 0 while the buffer is empty returns the byte most recently read out (0 after reset) and changes no flag.
- R10: When a byte arrives in the same cycle as a read of address 0, the read removes the oldest byte first and the new byte is then appended. A full buffer therefore does not overrun in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Byte from the deserializer |
| rx_valid | input | 1 | One-cycle strobe: `rx_data` holds a new byte |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe; applies read side effects at the edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rx_irq | output | 1 | Receive-data interrupt, level sensitive |

## Verification
The assertions assume that every input is known (not X) once reset is released, and that the depth parameter is a power of two, so that pointer wrap equals buffer wrap. They do not constrain how strobes combine: a read, a write and an arriving byte may all occur in one cycle. The bench drives every input at the falling edge from tasks, and its random phase sets only fully defined values. It mixes arrivals, reads of all four addresses and occasional control writes, so that the full, empty and same-cycle cases are reached within those limits.

// File: rtl/uart_rx_fifo_stat.sv
module uart_rx_fifo_stat #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic [1:0]    bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          rx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, lvl;
  logic [DW-1:0] last_rd;
  logic          ovr_q;
  logic [1:0]    trig_q;

  wire full   = count == CW'(DEPTH);
  wire nempty = count != '0;
  wire rx_rd  = bus_rd && bus_addr == 2'd0;
  wire pop    = rx_rd && nempty;
  wire push   = rx_valid && !(full && !pop);
  wire ovw    = rx_valid && full && !pop;
  wire lsr_rd = bus_rd && bus_addr == 2'd1;

  always_comb begin
    case (trig_q)
      2'd0:    lvl = CW'(LVL0);
      2'd1:    lvl = CW'(LVL1);
      2'd2:    lvl = CW'(LVL2);
      default: lvl = CW'(LVL3);
    endcase
  end

  assign rx_irq = count >= lvl;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {{(16-DW){1'b0}}, nempty ? mem[rd_ptr] : last_rd};
      2'd1:    bus_rdata = {14'h0, ovr_q, nempty};
      2'd2:    bus_rdata = {8'h0, trig_q, 6'h0};
      default: bus_rdata = 16'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= rx_data;
    if (ovw)  mem[wr_ptr - AW'(1)] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      last_rd <= '0;
      ovr_q   <= 1'b0;
      trig_q  <= 2'd0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop) begin
        rd_ptr  <= rd_ptr + AW'(1);
        last_rd <= mem[rd_ptr];
      end
      count <= count + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
      if (ovw)         ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;
      if (bus_wr && bus_addr == 2'd2) trig_q <= bus_wdata[7:6];
    end
  end
endmodule

module uart_rx_fifo_stat_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic [1:0]    bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [15:0]   bus_wdata,
  input logic [CW-1:0] count,
  input logic          ovr_q,
  input logic [1:0]    trig_q,
  input logic          rx_irq
);
  wire full  = count == CW'(DEPTH);
  wire rx_rd = bus_rd && bus_addr == 2'd0;

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_ovr_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_valid && full && !rx_rd));

  assert_ovr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1 && !(rx_valid && full && !rx_rd)) |=> !ovr_q);

  assert_dr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !rx_rd) |=> count != '0);

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && rx_rd && !rx_valid) |=> (count == '0 && $stable(ovr_q)));

  assert_full_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_rd && rx_valid) |=> (full && $stable(ovr_q)));

  assert_trig_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> trig_q == $past(bus_wdata[7:6]));

  assert_irq_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !rx_irq);
endmodule

bind uart_rx_fifo_stat uart_rx_fifo_stat_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .bus_addr(bus_addr),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .count(count),
  .ovr_q(ovr_q), .trig_q(trig_q), .rx_irq(rx_irq));

// File: tb/uart_rx_fifo_stat_tb.sv
module uart_rx_fifo_stat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rx_irq;

  always #10 clk = ~clk;

  uart_rx_fifo_stat u_dut (.*);

  logic [7:0] q[$];
  logic [7:0] m_last = '0;
  logic       m_ovr = 1'b0;
  logic [1:0] m_trig = '0;
  int checks = 0, fails = 0;
  bit done = 0;
  int lv[4] = '{1, 4, 8, 14};

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return {8'h0, q.size() != 0 ? q[0] : m_last};
      2'd1:    return {14'h0, m_ovr, q.size() != 0};
      2'd2:    return {8'h0, m_trig, 6'h0};
      default: return 16'h0;
    endcase
  endfunction

  task automatic step(input logic v, input logic [7:0] d, input logic rd, input logic wr,
                      input logic [1:0] a, input logic [15:0] wd, input string tag);
    bit ov;
    @(negedge clk);
    rx_valid = v; rx_data = d; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #1;
    check({tag, " rdata"}, bus_rdata, exp_rdata(a));
    check({tag, " irq"}, {15'h0, rx_irq}, {15'h0, q.size() >= lv[m_trig]});
    if (rst_n) begin
      if (rd && a == 2'd0 && q.size() != 0) m_last = q.pop_front();
      ov = 0;
      if (v) begin
        if (q.size() < 16) q.push_back(d);
        else begin q[15] = d; ov = 1; end
      end
      if (rd && a == 2'd1) m_ovr = 1'b0;
      if (ov) m_ovr = 1'b1;
      if (wr && a == 2'd2) m_trig = wd[7:6];
    end
  endtask

  task automatic push_b(input logic [7:0] d, input string tag);
    step(1, d, 0, 0, 2'd3, 16'h0, tag);
  endtask
  task automatic rd_reg(input logic [1:0] a, input string tag);
    step(0, 8'h00, 1, 0, a, 16'h0, tag);
  endtask
  task automatic wr_fcr(input logic [15:0] wd, input string tag);
    step(0, 8'h00, 0, 1, 2'd2, wd, tag);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    rst_n = 0;
    rd_reg(2'd0, "R1"); rd_reg(2'd1, "R1");
    @(negedge clk); rst_n = 1;
    rd_reg(2'd0, "R1"); rd_reg(2'd1, "R1"); rd_reg(2'd2, "R1"); rd_reg(2'd3, "R1");
    // R2 order, R3 level 1, R4 drop
    for (int i = 0; i < 3; i++) push_b(8'h10 + 8'(i), "R2");
    for (int i = 0; i < 3; i++) rd_reg(2'd0, "R4");
    rd_reg(2'd1, "R7");
    // R9 empty read keeps last value and flags
    rd_reg(2'd0, "R9"); rd_reg(2'd0, "R9"); rd_reg(2'd1, "R9");
    // R8 reserved bits and stray writes
    wr_fcr(16'hFFFF, "R8"); rd_reg(2'd2, "R8");
    step(0, 8'h00, 0, 1, 2'd0, 16'hFFFF, "R8"); step(0, 8'h00, 0, 1, 2'd1, 16'hFFFF, "R8");
    rd_reg(2'd2, "R8"); rd_reg(2'd1, "R8");
    // R3 each trigger level, R4 drop just below
    for (int t = 1; t < 4; t++) begin
      wr_fcr(16'(t) << 6, "R3");
      for (int i = 0; i < lv[t]; i++) push_b(8'h40 + 8'(i), "R3");
      rd_reg(2'd2, "R3");
      rd_reg(2'd0, "R4"); rd_reg(2'd1, "R4");
      while (q.size() != 0) rd_reg(2'd0, "R4");
    end
    // R5 overrun on full, R6 clear by status read, R7 data ready kept
    wr_fcr(16'h0000, "R5");
    for (int i = 0; i < 16; i++) push_b(8'h80 + 8'(i), "R2");
    push_b(8'hEE, "R5"); rd_reg(2'd1, "R5");
    rd_reg(2'd1, "R6"); rd_reg(2'd1, "R7");
    // R6 set in same cycle as status read
    step(1, 8'hDD, 1, 0, 2'd1, 16'h0, "R6"); rd_reg(2'd1, "R6");
    // R10 full buffer with same-cycle read and arrival
    step(1, 8'h55, 1, 0, 2'd0, 16'h0, "R10"); rd_reg(2'd1, "R10");
    rd_reg(2'd1, "R6");
    while (q.size() != 0) rd_reg(2'd0, "R5");
    rd_reg(2'd1, "R7");
    // R10 empty and partial same-cycle
    step(1, 8'hA1, 1, 0, 2'd0, 16'h0, "R10");
    step(1, 8'hA2, 1, 0, 2'd0, 16'h0, "R10");
    rd_reg(2'd0, "R10"); rd_reg(2'd0, "R10");
    // R2 random mix
    for (int i = 0; i < 2000; i++) begin
      logic v, rd, wr;
      logic [1:0] a;
      v = 1'($urandom_range(0, 1));
      rd = 1'($urandom_range(0, 2) != 0);
      wr = ($urandom_range(0, 19) == 0);
      a = 2'($urandom_range(0, 3));
      step(v, 8'($urandom), rd, wr, a, 16'($urandom), "R2");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule